// File: doc/BRIEF.md
# Tick Compare Timer Bank

This block holds three processor tick timers: a tick timer, a system tick timer and a hypervisor system tick timer. Each one has a 63-bit free-running counter, a 63-bit compare limit and a disabled flag. Bit 63 of every written word is read as the disabled flag and is never stored as a count or limit bit. The counter advances by one on each cycle in which that timer's tick enable is high. The enable comes from a rate divider outside the block, nominally 100 MHz for all three timers.

Writing a limit arms a one-shot compare. The timer fires when the value of the counter after the increment reaches the limit. A limit that is already at or behind the count fires on the very next tick. A limit whose value bits are zero, or whose bit 63 is set, leaves the timer unarmed.

When a timer fires it raises a one-cycle match pulse. The tick timer's match sets the tick soft-interrupt request. Either system tick timer sets the system-tick soft-interrupt request. Any match also raises a request to re-evaluate pending interrupts. Reading a counter returns its value with bit 63 set again whenever the timer is disabled.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every timer reads back 0x8000_0000_0000_0000 (disabled, count zero), and no match, soft-interrupt or evaluation request is raised.
- R2: A count write loads bits 62:0 of wrData into the selected counter and takes the disabled flag from bit 63. A read returns {disabled, count}.
- R3: The counter rises by exactly one on each cycle its tickEn is high with no count write. Otherwise it holds. A count write takes priority over the increment.
- R4: After a limit write with bit 63 clear and a nonzero value L, matchOut for that timer is high for one cycle. That is the cycle in which the counter first reads L after a tick.
- R5: A limit write whose bits 62:0 are zero arms nothing and cancels an earlier armed limit, so no match follows.
- R6: A limit write with bit 63 set disables the timer, and its read value shows bit 63 set. No match occurs while the disabled flag is set.
- R7: A limit written at or below the current count fires on the next cycle with tickEn high.
- R8: A timer fires once per limit write. After its match it stays silent until its limit is written again.
- R9: A match of timer 0 raises softTickSet. A match of timer 1 or timer 2 raises softSysSet. irqEvalReq is high in any cycle with a match. All three strobes coincide with matchOut.
- R10: The timers are independent. The enable, writes and match of one timer leave the others' counts and matches unchanged.
- R11: A match is only produced on a cycle in which that timer's tickEn is high. An armed timer with a reached limit waits for the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 3 | Per-timer count enable (one bit per timer) |
| cntWrEn | input | 3 | Per-timer count write strobe |
| limWrEn | input | 3 | Per-timer limit write strobe |
| wrData | input | 64 | Write word; bit 63 is the disable flag, bits 62:0 the value |
| rdSel | input | 2 | Timer whose count is shown on rdData |
| rdData | output | 64 | Selected count with bit 63 showing the disabled flag |
| matchOut | output | 3 | One-cycle match pulse per timer |
| softTickSet | output | 1 | Tick soft-interrupt set request |
| softSysSet | output | 1 | System-tick soft-interrupt set request |
| irqEvalReq | output | 1 | Request to re-evaluate interrupts |

## Verification
The bench targets the off-by-one edges of the compare. A limit reached exactly on a tick must fire in that cycle, not one late. A limit equal to or behind the count must fire on the next tick rather than never. A design that compared only for equality would miss every late limit forever. A zero or disabled limit must stay silent, and a design that armed on them would fire spurious soft interrupts. The bench also checks that the match stays a single pulse and is routed to the right soft bit. It checks that reads put the disable bit back, since a design that dropped it would report an enabled timer.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Strobes from the control half to the datapath half of one timer
  typedef struct packed {
    logic loadCnt;
    logic loadLim;
    logic incr;
  } dpStrobes_t;

endpackage

// File: rtl/tick_dp.sv
module tick_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-2:0] cntVal,
  output logic             reachedNext,
  output logic             wrValZero
);
  localparam int VAL_W = CNT_W - 1;

  logic [VAL_W-1:0] cntQ;
  logic [VAL_W-1:0] limQ;
  logic [VAL_W:0]   cntPlusOne;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      limQ <= '0;
    end else begin
      if (strobes.loadCnt)   cntQ <= wrData[VAL_W-1:0];
      else if (strobes.incr) cntQ <= cntQ + 1'b1;
      if (strobes.loadLim)   limQ <= wrData[VAL_W-1:0];
    end
  end

  // widened by one bit so the count just below wrap still compares correctly
  assign cntPlusOne  = {1'b0, cntQ} + 1'b1;
  assign reachedNext = (cntPlusOne >= {1'b0, limQ});
  assign wrValZero   = (wrData[VAL_W-1:0] == '0);
  assign cntVal      = cntQ;

  // R2: a count write lands in the counter
  a_r2_count_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCnt |=> cntQ == $past(wrData[VAL_W-1:0]));

  // R3: one step per enabled tick
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incr && !strobes.loadCnt) |=> cntQ == $past(cntQ) + 1'b1);

endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       cntWr,
  input  logic       limWr,
  input  logic       wrDisBit,
  input  logic       wrValZero,
  input  logic       reachedNext,
  output dpStrobes_t strobes,
  output logic       disabled,
  output logic       matchPulse
);
  logic disabledQ;
  logic armedQ;
  logic matchQ;
  logic fireNow;

  assign fireNow = armedQ && !disabledQ && tickEn && !cntWr && !limWr && reachedNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      disabledQ <= 1'b1;
      armedQ    <= 1'b0;
      matchQ    <= 1'b0;
    end else begin
      if (limWr || cntWr) disabledQ <= wrDisBit;
      if (limWr)          armedQ <= !wrDisBit && !wrValZero;
      else if (fireNow)   armedQ <= 1'b0;
      matchQ <= fireNow;
    end
  end

  always_comb begin
    strobes.loadCnt = cntWr;
    strobes.loadLim = limWr;
    strobes.incr    = tickEn && !cntWr;
  end

  assign disabled   = disabledQ;
  assign matchPulse = matchQ;

  // R8: the match never lasts two cycles
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    matchQ |=> !matchQ);

  // R6: nothing fires out of a disabled cycle
  a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    disabledQ |=> !matchQ);

  // R11: a match follows an enabled tick
  a_r11_fire_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    matchQ |-> $past(tickEn));

  // R5: a zero-valued limit leaves the timer unarmed
  a_r5_zero_limit_disarms: assert property (@(posedge clk) disable iff (!rstN)
    (limWr && wrValZero) |=> !armedQ);

endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             cntWr,
  input  logic             limWr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdVal,
  output logic             match
);
  localparam int VAL_W = CNT_W - 1;

  dpStrobes_t       strobes;
  logic [VAL_W-1:0] cntVal;
  logic             reachedNext;
  logic             wrValZero;
  logic             disabled;

  tick_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .cntWr      (cntWr),
    .limWr      (limWr),
    .wrDisBit   (wrData[CNT_W-1]),
    .wrValZero  (wrValZero),
    .reachedNext(reachedNext),
    .strobes    (strobes),
    .disabled   (disabled),
    .matchPulse (match)
  );

  tick_dp #(.CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (wrData),
    .cntVal     (cntVal),
    .reachedNext(reachedNext),
    .wrValZero  (wrValZero)
  );

  assign rdVal = {disabled, cntVal};

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int CNT_W      = 64,
  parameter int NUM_TIMERS = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_TIMERS-1:0]         tickEn,
  input  logic [NUM_TIMERS-1:0]         cntWrEn,
  input  logic [NUM_TIMERS-1:0]         limWrEn,
  input  logic [CNT_W-1:0]              wrData,
  input  logic [$clog2(NUM_TIMERS)-1:0] rdSel,
  output logic [CNT_W-1:0]              rdData,
  output logic [NUM_TIMERS-1:0]         matchOut,
  output logic                          softTickSet,
  output logic                          softSysSet,
  output logic                          irqEvalReq
);
  localparam int SEL_W = $clog2(NUM_TIMERS);

  logic [CNT_W-1:0] rdVals [NUM_TIMERS];

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
    tick_timer_unit #(.CNT_W(CNT_W)) unit_i (
      .clk   (clk),
      .rstN  (rstN),
      .tickEn(tickEn[t]),
      .cntWr (cntWrEn[t]),
      .limWr (limWrEn[t]),
      .wrData(wrData),
      .rdVal (rdVals[t]),
      .match (matchOut[t])
    );
  end

  always_comb begin
    rdData = '0;
    for (int t = 0; t < NUM_TIMERS; t++) begin
      if (rdSel == SEL_W'(t)) rdData = rdVals[t];
    end
  end

  // timer 0 is the plain tick; every later timer is a system tick
  assign softTickSet = matchOut[0];
  assign softSysSet  = |matchOut[NUM_TIMERS-1:1];
  assign irqEvalReq  = |matchOut;

endmodule

// File: tb/tick_timer_bank_tb_top.sv
module tick_timer_bank_tb_top;
  localparam logic [63:0] DIS = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  tickEn = '0;
  logic [2:0]  cntWrEn = '0;
  logic [2:0]  limWrEn = '0;
  logic [63:0] wrData = '0;
  logic [1:0]  rdSel = '0;
  logic [63:0] rdData;
  logic [2:0]  matchOut;
  logic        softTickSet, softSysSet, irqEvalReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tick_timer_bank dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntWrEn(cntWrEn),
    .limWrEn(limWrEn), .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .matchOut(matchOut), .softTickSet(softTickSet), .softSysSet(softSysSet),
    .irqEvalReq(irqEvalReq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input logic [2:0] expMatch);
    check(req, {58'd0, matchOut, softTickSet, softSysSet, irqEvalReq},
          {58'd0, expMatch, expMatch[0], |expMatch[2:1], |expMatch});
  endtask

  task automatic cycle(input logic [2:0] en);
    tickEn = en;
    @(posedge clk); #1;
    tickEn = '0;
  endtask

  task automatic writeCnt(input int idx, input logic [63:0] d);
    wrData = d; cntWrEn = 3'b001 << idx;
    @(posedge clk); #1;
    cntWrEn = '0;
  endtask

  task automatic writeLim(input int idx, input logic [63:0] d);
    wrData = d; limWrEn = 3'b001 << idx;
    @(posedge clk); #1;
    limWrEn = '0;
  endtask

  task automatic readCnt(input int idx, output logic [63:0] v);
    rdSel = 2'(idx);
    #1;
    v = rdData;
  endtask

  task automatic testReset();
    logic [63:0] v;
    for (int i = 0; i < 3; i++) begin
      readCnt(i, v);
      check("R1 reset read", v, DIS);
    end
    checkOut("R1 reset outputs", 3'b000);
  endtask

  task automatic testCountWrite();
    logic [63:0] v;
    writeCnt(1, 64'h1234);
    readCnt(1, v);
    check("R2 enabled count load", v, 64'h1234);
    writeCnt(1, DIS | 64'h5);
    readCnt(1, v);
    check("R2 disabled count load", v, DIS | 64'h5);
    cycle(3'b000);
    readCnt(1, v);
    check("R3 hold without tick", v, DIS | 64'h5);
  endtask

  task automatic testIncrement();
    logic [63:0] v;
    writeCnt(0, 64'd100);
    for (int i = 0; i < 7; i++) begin
      cycle(3'b001);
      if (i % 2 == 0) cycle(3'b000);
    end
    readCnt(0, v);
    check("R3 seven ticks", v, 64'd107);
    // write wins over a same-cycle tick
    wrData = 64'd40; cntWrEn = 3'b001; tickEn = 3'b001;
    @(posedge clk); #1;
    cntWrEn = '0; tickEn = '0;
    readCnt(0, v);
    check("R3 write over tick", v, 64'd40);
  endtask

  task automatic testMatch();
    logic [63:0] v;
    writeCnt(0, 64'd10);
    writeLim(0, 64'd15);
    for (int i = 1; i <= 5; i++) begin
      cycle(3'b001);
      checkOut("R4 R9 tick match timing", (i == 5) ? 3'b001 : 3'b000);
    end
    readCnt(0, v);
    check("R4 count at match", v, 64'd15);
    for (int i = 0; i < 5; i++) begin
      cycle(3'b001);
      checkOut("R8 one shot", 3'b000);
    end
  endtask

  task automatic testLate();
    writeCnt(1, 64'd50);
    writeLim(1, 64'd20);
    for (int i = 0; i < 3; i++) begin
      cycle(3'b000);
      checkOut("R11 waits for tick", 3'b000);
    end
    cycle(3'b010);
    checkOut("R7 R9 past limit fires", 3'b010);
    writeLim(1, 64'd51);
    cycle(3'b010);
    checkOut("R7 equal limit fires", 3'b010);
  endtask

  task automatic testZeroLimit();
    logic [63:0] v;
    writeCnt(2, 64'd0);
    writeLim(2, 64'd5);
    writeLim(2, 64'd0);
    for (int i = 0; i < 10; i++) begin
      cycle(3'b100);
      checkOut("R5 zero limit silent", 3'b000);
    end
    readCnt(2, v);
    check("R5 count after zero limit", v, 64'd10);
  endtask

  task automatic testDisabledLimit();
    logic [63:0] v;
    writeLim(2, DIS | 64'd12);
    for (int i = 0; i < 5; i++) begin
      cycle(3'b100);
      checkOut("R6 disabled limit silent", 3'b000);
    end
    readCnt(2, v);
    check("R6 read reinserts disable", v, DIS | 64'd15);
    writeCnt(2, 64'd3);
    for (int i = 0; i < 12; i++) begin
      cycle(3'b100);
      checkOut("R6 not armed by disabled limit", 3'b000);
    end
  endtask

  task automatic testIndependence();
    logic [63:0] v;
    writeCnt(0, 64'd0);
    writeCnt(2, 64'd0);
    writeLim(0, 64'd3);
    writeLim(2, 64'd3);
    for (int i = 1; i <= 3; i++) begin
      cycle(3'b001);
      checkOut("R10 only timer0", (i == 3) ? 3'b001 : 3'b000);
    end
    readCnt(2, v);
    check("R10 timer2 untouched", v, 64'd0);
    for (int i = 1; i <= 3; i++) begin
      cycle(3'b100);
      checkOut("R10 R9 timer2 system tick", (i == 3) ? 3'b100 : 3'b000);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testCountWrite();
    testIncrement();
    testMatch();
    testLate();
    testZeroLimit();
    testDisabledLimit();
    testIndependence();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule